// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the timing of a two-wire serial master from the system clock. A chain of counters divides the system clock: a half-period counter divides it by 2 × (H + 1), a power-of-two prescaler divides by 2^E, and a multiplier stage divides by (D + 1). The result is the base tick, a one-cycle pulse at ten times the serial clock rate. A fixed divide-by-ten stage then produces a square serial clock reference. With these counts, f_scl = f_sys / (2 × (H + 1)) / 2^E / (D + 1) / 10.

Software programs the half-period count H through one write strobe and the divisor byte (D and E) through another. Written values are held pending. They become active only when a serial clock period ends, so a reprogram never shortens or stretches a half period. Values that would break the bus timing are clamped as they are written. A synchronous clear restarts every counter from zero, drives the reference high and activates the pending values at once.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset the active settings are H = 24, D = 2, E = 0. The base tick period is then 150 system cycles and the serial clock reference is high.
- R2: The base tick pulses once every 2 × (H + 1) × 2^E × (D + 1) system cycles.
- R3: In the divisor byte, bits 6:3 carry D and bits 2:0 carry E. Bit 7 has no effect on the period.
- R4: A written D below 2 is stored as 2.
- R5: A written H below 5 is stored as 5.
- R6: The serial clock reference changes only in the cycle after a base tick. It stays high for 5 ticks and then low for 5 ticks, so each half period lasts 5 base tick periods.
- R7: Written settings become active at the next rising edge of the serial clock reference. Ticks before that edge keep the old period, and the first tick after it comes one new period minus one cycle later.
- R8: A clear zeroes all counters, holds the reference high and activates the pending settings. The first tick then comes period − 1 cycles after the clear is taken, and no tick is asserted in the cycle that follows the clear.
- R9: The base tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all counters; activates pending settings |
| hp_we | input | 1 | Write strobe for the half-period count |
| hp_wdata | input | 8 | Half-period count H |
| div_we | input | 1 | Write strobe for the divisor byte |
| div_wdata | input | 8 | Divisor byte: D in bits 6:3, E in bits 2:0 |
| tick_o | output | 1 | Base tick, one cycle wide, ten per serial clock period |
| scl_o | output | 1 | Serial clock reference |

## Verification
The tick, the reference and the loading of settings all come from registers. Each result therefore appears at the first sampling point after the edge that updates it. The bench drives inputs and samples outputs on falling edges and counts those falling edges. A clear or a rising reference must give its first tick exactly period − 1 samples later. Consecutive ticks must be exactly one period apart, and a reference half period must last exactly five periods. Because all checks are cycle-exact intervals, one extra register or a wrong terminal count anywhere in the chain shows up as a mismatch.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int HP_W    = 8;
  localparam int DM_W    = 4;
  localparam int DE_W    = 3;
  localparam int OSC_DIV = 10;
  localparam int HP_MIN  = 5;
  localparam int DM_MIN  = 2;
  localparam logic [HP_W-1:0] HP_RST = 8'h18;
  localparam logic [DM_W-1:0] DM_RST = 4'd2;
  localparam logic [DE_W-1:0] DE_RST = 3'd0;

  typedef struct packed {
    logic [HP_W-1:0] hp;
    logic [DM_W-1:0] dm;
    logic [DE_W-1:0] de;
  } div_cfg_t;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_div_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            hp_we,
  input  logic [7:0]      hp_wdata,
  input  logic            div_we,
  input  logic [7:0]      div_wdata,
  output div_cfg_t        act_cfg
);
  localparam int DE_LSB = 0;
  localparam int DM_LSB = DE_LSB + DE_W;

  div_cfg_t pend_q, pend_nx, act_q, act_nx;
  logic [HP_W-1:0] hp_in;
  logic [DM_W-1:0] dm_in;
  logic [DE_W-1:0] de_in;

  always_comb begin
    hp_in = hp_wdata[HP_W-1:0];
    if (hp_in < HP_W'(HP_MIN)) hp_in = HP_W'(HP_MIN);
    dm_in = div_wdata[DM_LSB +: DM_W];
    if (dm_in < DM_W'(DM_MIN)) dm_in = DM_W'(DM_MIN);
    de_in = div_wdata[DE_LSB +: DE_W];
  end

  always_comb begin
    pend_nx = pend_q;
    if (hp_we) pend_nx.hp = hp_in;
    if (div_we) begin
      pend_nx.dm = dm_in;
      pend_nx.de = de_in;
    end
    act_nx = act_q;
    if (load) act_nx = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '{hp: HP_RST, dm: DM_RST, de: DE_RST};
      act_q  <= '{hp: HP_RST, dm: DM_RST, de: DE_RST};
    end else begin
      if (hp_we || div_we) pend_q <= pend_nx;
      if (load) act_q <= act_nx;
    end
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/scl_div_halfper.sv
module scl_div_halfper
  import scl_div_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [HP_W-1:0] hp,
  output logic            pulse
);
  logic [HP_W-1:0] cnt_q, cnt_nx;
  logic            ph_q, ph_nx;
  logic            wrap;

  always_comb begin
    wrap   = (cnt_q == hp);
    pulse  = wrap && ph_q;
    cnt_nx = wrap ? '0 : cnt_q + 1'b1;
    ph_nx  = wrap ? ~ph_q : ph_q;
    if (clr) begin
      cnt_nx = '0;
      ph_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      ph_q  <= ph_nx;
    end
  end
endmodule

// File: rtl/scl_div_chain.sv
module scl_div_chain
  import scl_div_pkg::*;
#(
  parameter int PRE_W = (1 << DE_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            in_pulse,
  input  logic [DE_W-1:0] de,
  input  logic [DM_W-1:0] dm,
  output logic            tick
);
  logic [PRE_W-1:0] pre_q, pre_nx, pre_lim;
  logic [DM_W-1:0]  mul_q, mul_nx;
  logic             pre_en, pre_term, mul_en, mul_term;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_lim[i] = (i < int'(de));
  end

  always_comb begin
    pre_term = (pre_q == pre_lim);
    mul_term = (mul_q == dm);
    pre_en   = in_pulse || clr;
    mul_en   = (in_pulse && pre_term) || clr;
    tick     = in_pulse && pre_term && mul_term;
    pre_nx   = pre_term ? '0 : pre_q + 1'b1;
    mul_nx   = mul_term ? '0 : mul_q + 1'b1;
    if (clr) begin
      pre_nx = '0;
      mul_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      mul_q <= '0;
    end else begin
      if (pre_en) pre_q <= pre_nx;
      if (mul_en) mul_q <= mul_nx;
    end
  end
endmodule

// File: rtl/scl_div_osc.sv
module scl_div_osc
  import scl_div_pkg::*;
#(
  parameter int DIV = OSC_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic scl,
  output logic boundary
);
  localparam int OSC_W = $clog2(DIV);
  localparam int HALF  = DIV / 2;

  logic [OSC_W-1:0] cnt_q, cnt_nx;
  logic             scl_q, scl_nx;
  logic             at_last, at_half, en;

  always_comb begin
    at_last  = (cnt_q == OSC_W'(DIV - 1));
    at_half  = (cnt_q == OSC_W'(HALF - 1));
    boundary = tick && at_last;
    en       = tick || clr;
    cnt_nx   = at_last ? '0 : cnt_q + 1'b1;
    scl_nx   = scl_q;
    if (at_last) scl_nx = 1'b1;
    else if (at_half) scl_nx = 1'b0;
    if (clr) begin
      cnt_nx = '0;
      scl_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      scl_q <= 1'b1;
    end else if (en) begin
      cnt_q <= cnt_nx;
      scl_q <= scl_nx;
    end
  end

  assign scl = scl_q;
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       hp_we,
  input  logic [7:0] hp_wdata,
  input  logic       div_we,
  input  logic [7:0] div_wdata,
  output logic       tick_o,
  output logic       scl_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  div_cfg_t        act_cfg;
  logic [HP_W-1:0] act_hp;
  logic [DM_W-1:0] act_dm;
  logic [DE_W-1:0] act_de;
  logic            hp_pulse, tick, boundary, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign load   = boundary || clr;
  assign act_hp = act_cfg.hp;
  assign act_dm = act_cfg.dm;
  assign act_de = act_cfg.de;

  scl_div_cfg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .load(load),
    .hp_we(hp_we), .hp_wdata(hp_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .act_cfg(act_cfg)
  );

  scl_div_halfper u_hp (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .hp(act_hp), .pulse(hp_pulse)
  );

  scl_div_chain u_chain (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .in_pulse(hp_pulse),
    .de(act_de), .dm(act_dm), .tick(tick)
  );

  scl_div_osc u_osc (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .tick(tick),
    .scl(scl_o), .boundary(boundary)
  );

  assign tick_o = tick;
endmodule

// File: rtl/scl_clock_gen_chk.sv
module scl_clock_gen_chk
  import scl_div_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic            tick,
  input logic            scl,
  input logic [HP_W-1:0] hp,
  input logic [DM_W-1:0] dm,
  input logic [DE_W-1:0] de
);
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_scl_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(scl) && !$past(clr)) |-> $past(tick));

  assert_clear_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (scl && !tick));

  assert_dm_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dm >= DM_W'(DM_MIN));

  assert_hp_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hp >= HP_W'(HP_MIN));

  assert_load_at_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({hp, dm, de}) |-> ($rose(scl) || $past(clr)));
endmodule

bind scl_clock_gen scl_clock_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick_o), .scl(scl_o),
  .hp(act_hp), .dm(act_dm), .de(act_de)
);

// File: tb/test_scl_clock_gen.sv
module test_scl_clock_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic hp_we = 1'b0;
  logic div_we = 1'b0;
  logic [7:0] hp_wdata = 8'h0;
  logic [7:0] div_wdata = 8'h0;
  logic tick_o, scl_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_clock_gen i_scl_clock_gen (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hp_we(hp_we), .hp_wdata(hp_wdata),
    .div_we(div_we), .div_wdata(div_wdata),
    .tick_o(tick_o), .scl_o(scl_o)
  );

  function automatic int exp_period(int h, int byte_v);
    int d, e;
    d = (byte_v >> 3) & 15;
    e = byte_v & 7;
    if (h < 5) h = 5;
    if (d < 2) d = 2;
    return 2 * (h + 1) * (1 << e) * (d + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(int h, int byte_v);
    @(negedge clk);
    hp_we = 1'b1; hp_wdata = 8'(h);
    div_we = 1'b1; div_wdata = 8'(byte_v);
    @(negedge clk);
    hp_we = 1'b0; div_we = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    while (!tick_o) begin @(negedge clk); n++; end
  endtask

  task automatic meas_gap(output int g);
    @(negedge clk);
    while (!tick_o) @(negedge clk);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick_o);
  endtask

  task automatic wait_scl(bit lvl);
    @(negedge clk);
    while (scl_o == lvl) @(negedge clk);
    while (scl_o != lvl) @(negedge clk);
  endtask

  task automatic meas_low(output int n);
    wait_scl(1'b0);
    n = 0;
    while (!scl_o) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    int n, p, h, b, seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl high after reset", int'(scl_o), 1);
    check("R1 no tick after reset", int'(tick_o), 0);
    meas_gap(n);
    check("R1 default period", n, 150);
    // R9: cycle after a tick is quiet
    @(negedge clk);
    check("R9 tick one cycle", int'(tick_o), 0);

    // R8: clear restart with defaults
    do_clear();
    check("R8 scl high after clear", int'(scl_o), 1);
    count_to_tick(n);
    check("R8 first tick after clear", n, 149);

    // R3 R4 R5: H=3 -> 5, D=0 -> 2, E=1, bit 7 set
    write_cfg(3, 8'h80 | (0 << 3) | 1);
    do_clear();
    count_to_tick(n);
    check("R5 R4 R3 clamped first tick", n, 71);
    meas_gap(n);
    check("R2 R3 clamped period", n, 72);
    meas_low(n);
    check("R6 scl half period", n, 5 * 72);

    // R7: reprogram mid-period, old period holds until rising edge
    wait_scl(1'b0);
    write_cfg(6, (3 << 3) | 0);
    meas_gap(n);
    check("R7 old period before edge", n, 72);
    wait_scl(1'b1);
    count_to_tick(n);
    check("R7 first tick after edge", n, 55);
    meas_gap(n);
    check("R7 new period", n, 56);

    // R3: same D and E with bit 7 toggled gives same period
    write_cfg(6, 8'h80 | (3 << 3));
    do_clear();
    meas_gap(n);
    check("R3 bit7 ignored", n, 56);

    // R2 R6 R8 random settings
    for (int k = 0; k < 6; k++) begin
      h = int'($urandom_range(0, 20));
      b = (int'($urandom_range(0, 1)) << 7) | (int'($urandom_range(0, 6)) << 3)
          | int'($urandom_range(0, 2));
      p = exp_period(h, b);
      write_cfg(h, b);
      do_clear();
      check("R8 scl high after clear", int'(scl_o), 1);
      count_to_tick(n);
      check("R8 random first tick", n, p - 1);
      meas_gap(n);
      check("R2 random period", n, p);
      meas_low(n);
      check("R6 random half period", n, 5 * p);
    end
    finish_run();
  end
endmodule